// File: doc/BRIEF.md
# Subscriber Line Mode and Status Controller

This block is the digital control core of an analog subscriber-line interface. A line-card controller selects the mode with two inputs: a standby select and a ring request. The analog front end supplies two raw detector levels, loop current present and ground-key current present. The block brings the mode inputs and the detector levels into the clock domain. It filters each detector with its own programmable delay. It then drives four outputs: an active-low hook status, an active-low ground-key status, an active-low codec power-up request and a ring-injector enable.

The centre of the block is a four-state machine. The states are `ST_STANDBY`, `ST_ACTIVE`, `ST_RINGING` and `ST_TRIPPED`, and the transitions are these:
- standby select high moves any state to `ST_STANDBY`, and standby has priority over every other condition;
- with standby low, `ST_STANDBY` goes to `ST_RINGING` when the ring request is high and to `ST_ACTIVE` when it is low;
- `ST_ACTIVE` goes to `ST_RINGING` on a ring request;
- `ST_RINGING` goes to `ST_ACTIVE` when the request drops, and goes to `ST_TRIPPED` when the filtered loop detector reports off-hook (ring trip);
- `ST_TRIPPED` stays put until the request drops, and then goes to `ST_ACTIVE`.

The ring enable falls in the same cycle that the filtered hook detector rises, so ringing is cut before the state register has moved. The detector filters advance only on cycles where `tick` is high. The hook delay must stay well below half a ringing period.

Top module: `line_mode_ctrl`

## Requirements
- R1: After a synchronous reset the block is in standby, with `hook_n`=1, `gkey_n`=1, `codec_pu_n`=1 and `ring_en`=0.
- R2: While in standby the outputs are held at `hook_n`=1, `gkey_n`=1, `codec_pu_n`=1 and `ring_en`=0, whatever the raw detector inputs are.
- R3: A change on `standby_in` or `ring_req_in` reaches the outputs three clock edges after the input changes (two synchronizer flops plus the state register). It has no effect after two edges.
- R4: In active mode `hook_n` is the inverse of the filtered loop detector and `gkey_n` is the inverse of the filtered ground-key detector. `codec_pu_n` is 0 exactly when off-hook is seen, and `ring_en`=0.
- R5: In ringing mode with no ring trip, `ring_en`=1 and `codec_pu_n`=0.
- R6: During ringing, when the filtered loop detector rises, `ring_en` drops to 0 and `hook_n` drops to 0 in that same cycle.
- R7: After a ring trip, `ring_en`=0, `hook_n`=0 and `codec_pu_n`=0 are held even when loop current goes away. They are held until the ring request returns to 0, which restores active mode.
- R8: A filtered detector takes the new level of its raw input only after that level has been present on N consecutive tick cycles. N is the delay input, and 0 is treated as 1. The first such tick is sampled three edges after the raw change.
- R9: On cycles where `tick` is 0 the detector filters neither count nor change.
- R10: A raw detector pulse shorter than N ticks does not change the filtered output.
- R11: Standby select overrides both ringing mode and the ring-trip latch. Leaving standby with the ring request still high re-enters ringing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Detector filter count enable |
| standby_in | input | 1 | Standby select from the line-card controller |
| ring_req_in | input | 1 | Ring request from the line-card controller |
| loop_raw | input | 1 | Raw loop-current detector level |
| gkey_raw | input | 1 | Raw ground-key detector level |
| hook_dly | input | DLY_W | Hook filter delay in ticks |
| gkey_dly | input | DLY_W | Ground-key filter delay in ticks |
| hook_n | output | 1 | Hook status, 0 = off-hook or ring trip |
| gkey_n | output | 1 | Ground-key status, 0 = ground key on |
| codec_pu_n | output | 1 | Codec power-up request, active low |
| ring_en | output | 1 | Ring-injector enable |

## Verification
Each mode input change is due three edges after the driver applies it. With `tick` held high, a detector change is due 2+N edges later. A ring trip shows on `ring_en` in that same cycle and not one cycle later. The driver records the cycle number at which each expected output set falls due. It also records the last cycle before that, where the old values must still hold. The monitor compares only at those recorded cycles and samples on the falling clock edge.

// File: rtl/line_ctrl_pkg.sv
package line_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_RINGING = 2'd2,
        ST_TRIPPED = 2'd3
    } line_state_t;

    localparam int NUM_DET = 2;
    localparam int DET_HOOK = 0;
    localparam int DET_GKEY = 1;
endpackage

// File: rtl/line_sync2.sv
module line_sync2 #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // R3: the output is the input delayed by exactly two edges
    p_sync_delay_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(rst, 2) |-> q == $past(d, 2));
endmodule

// File: rtl/line_det_filter.sv
module line_det_filter #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             raw,
    input  logic [DLY_W-1:0] dly,
    output logic             filt
);
    localparam int CW = DLY_W + 1;

    logic [DLY_W-1:0] cnt;
    logic [CW-1:0]    cnt_inc;
    logic             reached;

    assign cnt_inc = {1'b0, cnt} + CW'(1);
    assign reached = cnt_inc >= {1'b0, dly};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            filt <= 1'b0;
        end else if (tick) begin
            if (raw == filt) begin
                cnt <= '0;
            end else if (reached) begin
                filt <= raw;
                cnt  <= '0;
            end else begin
                cnt <= cnt_inc[DLY_W-1:0];
            end
        end
    end

    // R9: no tick, no movement
    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(tick) |-> $stable(filt) && $stable(cnt));
    // R8: a change only follows a tick that saw a differing raw level
    p_change_cause_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$stable(filt) |-> $past(tick) && $past(raw) == filt);
    // R10: a tick that sees agreement clears the run count
    p_run_clear_r10: assert property (@(posedge clk) disable iff (rst)
        tick && raw == filt |=> cnt == '0);
endmodule

// File: rtl/line_mode_fsm.sv
module line_mode_fsm
    import line_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sby,
    input  logic ring_req,
    input  logic hook_f,
    input  logic gkey_f,
    output logic hook_n,
    output logic gkey_n,
    output logic codec_pu_n,
    output logic ring_en
);
    line_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_STANDBY: begin
                if (!sby) state_nxt = ring_req ? ST_RINGING : ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (sby)           state_nxt = ST_STANDBY;
                else if (ring_req) state_nxt = ST_RINGING;
            end
            ST_RINGING: begin
                if (sby)            state_nxt = ST_STANDBY;
                else if (!ring_req) state_nxt = ST_ACTIVE;
                else if (hook_f)    state_nxt = ST_TRIPPED;
            end
            ST_TRIPPED: begin
                if (sby)            state_nxt = ST_STANDBY;
                else if (!ring_req) state_nxt = ST_ACTIVE;
            end
            default: state_nxt = ST_STANDBY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_STANDBY;
        else     state <= state_nxt;
    end

    always_comb begin
        hook_n     = 1'b1;
        gkey_n     = 1'b1;
        codec_pu_n = 1'b1;
        ring_en    = 1'b0;
        unique case (state)
            ST_STANDBY: begin
                hook_n     = 1'b1;
                gkey_n     = 1'b1;
                codec_pu_n = 1'b1;
                ring_en    = 1'b0;
            end
            ST_ACTIVE: begin
                hook_n     = !hook_f;
                gkey_n     = !gkey_f;
                codec_pu_n = !hook_f;
            end
            ST_RINGING: begin
                hook_n     = !hook_f;
                gkey_n     = !gkey_f;
                codec_pu_n = 1'b0;
                ring_en    = !hook_f;
            end
            ST_TRIPPED: begin
                hook_n     = 1'b0;
                gkey_n     = !gkey_f;
                codec_pu_n = 1'b0;
            end
            default: ;
        endcase
    end

    // R11: standby select always lands in standby
    p_sby_wins_r11: assert property (@(posedge clk) disable iff (rst)
        sby |=> state == ST_STANDBY);
    // R7: trip latch holds while the request stays and standby is off
    p_trip_hold_r7: assert property (@(posedge clk) disable iff (rst)
        state == ST_TRIPPED && ring_req && !sby |=> state == ST_TRIPPED);
    // R6: injector never drives while hook reports off-hook
    p_ring_vs_hook_r6: assert property (@(posedge clk) disable iff (rst)
        ring_en |-> hook_n);
    // R5: ringing always requests codec power
    p_ring_pu_r5: assert property (@(posedge clk) disable iff (rst)
        ring_en |-> !codec_pu_n);
endmodule

// File: rtl/line_mode_ctrl.sv
module line_mode_ctrl
    import line_ctrl_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             standby_in,
    input  logic             ring_req_in,
    input  logic             loop_raw,
    input  logic             gkey_raw,
    input  logic [DLY_W-1:0] hook_dly,
    input  logic [DLY_W-1:0] gkey_dly,
    output logic             hook_n,
    output logic             gkey_n,
    output logic             codec_pu_n,
    output logic             ring_en
);
    localparam int SYNC_W = 2 + NUM_DET;

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic [NUM_DET-1:0] det_raw, det_filt;
    logic [DLY_W-1:0]   det_dly [NUM_DET];

    assign sync_in = {gkey_raw, loop_raw, ring_req_in, standby_in};

    line_sync2 #(
        .W       (SYNC_W),
        .RST_VAL (SYNC_W'(1))
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_in),
        .q   (sync_out)
    );

    assign det_raw[DET_HOOK] = sync_out[2];
    assign det_raw[DET_GKEY] = sync_out[3];
    assign det_dly[DET_HOOK] = hook_dly;
    assign det_dly[DET_GKEY] = gkey_dly;

    for (genvar i = 0; i < NUM_DET; i++) begin : g_det
        line_det_filter #(.DLY_W(DLY_W)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .tick (tick),
            .raw  (det_raw[i]),
            .dly  (det_dly[i]),
            .filt (det_filt[i])
        );
    end

    line_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sby        (sync_out[0]),
        .ring_req   (sync_out[1]),
        .hook_f     (det_filt[DET_HOOK]),
        .gkey_f     (det_filt[DET_GKEY]),
        .hook_n     (hook_n),
        .gkey_n     (gkey_n),
        .codec_pu_n (codec_pu_n),
        .ring_en    (ring_en)
    );

    // R1: the first cycle after reset shows the standby output set
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> hook_n && gkey_n && codec_pu_n && !ring_en);
endmodule

// File: tb/line_mode_ctrl_tb.sv
module line_mode_ctrl_tb;
    localparam int DLY_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic standby_in = 1'b1, ring_req_in = 1'b0, loop_raw = 1'b0, gkey_raw = 1'b0;
    logic [DLY_W-1:0] hook_dly = 8'd2, gkey_dly = 8'd3;
    logic hook_n, gkey_n, codec_pu_n, ring_en;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        int    due;
        logic  h, g, p, r;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    line_mode_ctrl #(.DLY_W(DLY_W)) u_dut (
        .clk(clk), .rst(rst), .tick(tick),
        .standby_in(standby_in), .ring_req_in(ring_req_in),
        .loop_raw(loop_raw), .gkey_raw(gkey_raw),
        .hook_dly(hook_dly), .gkey_dly(gkey_dly),
        .hook_n(hook_n), .gkey_n(gkey_n),
        .codec_pu_n(codec_pu_n), .ring_en(ring_en)
    );

    // monitor: compares each expectation in the cycle it falls due
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (e.due != cyc || {hook_n, gkey_n, codec_pu_n, ring_en} !== {e.h, e.g, e.p, e.r}) begin
                    fails++;
                    $display("FAIL %s at cycle %0d: got h/g/p/r=%b%b%b%b expected %b%b%b%b",
                             e.tag, cyc, hook_n, gkey_n, codec_pu_n, ring_en, e.h, e.g, e.p, e.r);
                end
            end
        end
    end

    task automatic expect_in(int d, logic h, logic g, logic p, logic r, string tag);
        exp_t e;
        e.due = cyc + d; e.h = h; e.g = g; e.p = p; e.r = r; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic drive(logic s, logic rq, logic lp, logic gk);
        standby_in = s; ring_req_in = rq; loop_raw = lp; gkey_raw = gk;
    endtask

    initial begin
        wait_n(3);
        rst = 1'b0;
        // R1: reset state
        expect_in(1, 1, 1, 1, 0, "R1 reset state");
        drain();

        // R2: standby ignores detectors
        drive(1, 0, 1, 1);
        expect_in(12, 1, 1, 1, 0, "R2 standby masks detectors");
        drain();
        drive(1, 0, 0, 0);
        wait_n(10);

        // R3 + R4: leave standby, on-hook active
        drive(0, 0, 0, 0);
        expect_in(2, 1, 1, 1, 0, "R3 no effect after two edges");
        expect_in(3, 1, 1, 1, 0, "R4 active on-hook");
        drain();

        // R8 + R4: off-hook, hook delay 2 -> due at +4
        drive(0, 0, 1, 0);
        expect_in(3, 1, 1, 1, 0, "R8 hook not yet filtered");
        expect_in(4, 0, 1, 0, 0, "R4 off-hook powers codec");
        drain();

        // R8: ground key, delay 3 -> due at +5
        drive(0, 0, 1, 1);
        expect_in(4, 0, 1, 0, 0, "R8 gkey not yet filtered");
        expect_in(5, 0, 0, 0, 0, "R4 ground key on");
        drain();

        drive(0, 0, 0, 0);
        expect_in(5, 1, 1, 1, 0, "R4 back on-hook");
        drain();

        // R5: ringing
        drive(0, 1, 0, 0);
        expect_in(2, 1, 1, 1, 0, "R3 ring request not yet seen");
        expect_in(3, 1, 1, 0, 1, "R5 ringing enables injector");
        drain();

        // R6: ring trip
        drive(0, 1, 1, 0);
        expect_in(3, 1, 1, 0, 1, "R6 ringing before trip");
        expect_in(4, 0, 1, 0, 0, "R6 ring trip cuts injector");
        drain();

        // R7: latched after loop current goes away
        drive(0, 1, 0, 0);
        expect_in(12, 0, 1, 0, 0, "R7 trip latched");
        drain();
        drive(0, 0, 0, 0);
        expect_in(3, 1, 1, 1, 0, "R7 request removal restores active");
        drain();

        // R9: tick gating during ringing
        drive(0, 1, 0, 0);
        expect_in(3, 1, 1, 0, 1, "R5 ringing again");
        drain();
        tick = 1'b0;
        drive(0, 1, 1, 0);
        expect_in(20, 1, 1, 0, 1, "R9 no tick freezes filter");
        drain();
        tick = 1'b1;
        expect_in(1, 1, 1, 0, 1, "R9 first tick counts only");
        expect_in(2, 0, 1, 0, 0, "R9 second tick completes trip");
        drain();
        drive(0, 0, 0, 0);
        expect_in(8, 1, 1, 1, 0, "R7 active after tripped");
        drain();

        // R10: short pulse rejected
        drive(0, 0, 1, 0);
        expect_in(4, 1, 1, 1, 0, "R10 short pulse hook");
        expect_in(8, 1, 1, 1, 0, "R10 short pulse hook late");
        @(negedge clk);
        drive(0, 0, 0, 0);
        drain();

        // R11: standby overrides ringing, re-enter ringing afterwards
        drive(0, 1, 0, 0);
        expect_in(3, 1, 1, 0, 1, "R11 ringing before standby");
        drain();
        drive(1, 1, 0, 0);
        expect_in(2, 1, 1, 0, 1, "R11 standby not yet seen");
        expect_in(3, 1, 1, 1, 0, "R11 standby overrides ringing");
        drain();
        drive(0, 1, 0, 0);
        expect_in(3, 1, 1, 0, 1, "R11 re-enter ringing");
        drain();

        // R11: standby clears trip latch
        drive(0, 1, 1, 0);
        expect_in(4, 0, 1, 0, 0, "R6 trip again");
        drain();
        drive(1, 1, 1, 0);
        expect_in(3, 1, 1, 1, 0, "R2 standby from tripped");
        drain();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_n(5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule